// File: doc/BRIEF.md
# Rename History Buffer with Rollback

This block keeps an ordered log of register renames for one thread of an out-of-order core. Each time a destination operand is renamed, the rename stage pushes a record holding the instruction's sequence number, the architectural register, the physical register just allocated and the physical register that mapping replaced. Allocation also raises a strobe that tells the scoreboard the new physical register is not ready.

Two walks consume the log, one record per clock. A squash to sequence number S undoes, newest first, every record younger than S. Each step produces a map-table write that points the architectural register back at its previous physical register. It also returns the newly allocated register to the free list. Registers numbered at or above the count of ordinary physical registers get a scoreboard-ready write as well. A commit to sequence number C retires, oldest first, every record at or below C and frees the replaced physical register. A flush undoes the whole log. The map table, free list and scoreboard sit outside the block and follow its output strobes.

Top module: `rename_hist_buf`

## Requirements
- R1: After reset no output strobe is active, `busy` is low and `push_ready` is high.
- R2: A push with `push_valid` and `push_ready` both high stores one record, and on the next clock `sb_clr_valid` pulses with `sb_clr_preg` equal to the pushed new register. `push_ready` is low once DEPTH records are held, and a push attempted then stores nothing.
- R3: A squash to S undoes records whose sequence number is greater than S (unsigned), newest first, one per cycle. Each undo shows `map_wr_valid` with (`map_wr_areg`, `map_wr_preg`) = (architectural, previous) and `free_valid` with `free_preg` = new register. The first undo appears the clock after the request.
- R4: During an undo, `sb_set_valid` pulses with `sb_set_preg` = new register exactly when that register index is at or above NUM_PHYS.
- R5: A nonzero `commit_seq` C retires records with sequence number at most C, oldest first, one per cycle, each giving `free_valid` with `free_preg` = previous register and no map write.
- R6: A commit has no effect when `commit_seq` is zero, when the log is empty, or when the oldest record is already younger than C.
- R7: A commit is ignored in a cycle that carries a squash or flush, and while an undo walk is in progress.
- R8: `flush` undoes every record, newest first, regardless of sequence numbers.
- R9: `busy` is high while a walk has further records to process, and `push_ready` is low while `busy` is high or a squash or flush is presented.
- R10: A squash arriving during a commit walk ends the commit walk and starts the undo walk in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Record push request |
| push_seq | input | SEQ_W | Sequence number of the renamed instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_new_preg | input | PREG_W | Newly allocated physical register |
| push_prev_preg | input | PREG_W | Physical register previously mapped |
| push_ready | output | 1 | A push is accepted this cycle |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Squash bound; younger records are undone |
| flush | input | 1 | Undo every record |
| commit_seq | input | SEQ_W | Commit bound; zero means no commit |
| busy | output | 1 | Walk in progress |
| map_wr_valid | output | 1 | Map-table restore strobe |
| map_wr_areg | output | AREG_W | Architectural register to restore |
| map_wr_preg | output | PREG_W | Physical register to restore it to |
| free_valid | output | 1 | Free-list return strobe |
| free_preg | output | PREG_W | Physical register to return |
| sb_set_valid | output | 1 | Scoreboard mark-ready strobe |
| sb_set_preg | output | PREG_W | Register to mark ready |
| sb_clr_valid | output | 1 | Scoreboard mark-not-ready strobe |
| sb_clr_preg | output | PREG_W | Register to mark not ready |

## Verification
Every output strobe is registered. A request sampled at clock edge k produces its first undo or retire just after edge k, and the n-th step of a walk appears just after edge k+n-1. The allocation strobe follows a push by one edge. `busy` drops at the same edge that shows the last step. The bench drives inputs on the falling edge and samples after the next falling edge, so it reads each step once, in order. After each walk it takes one more sample to confirm the walk stopped at the right record and that ignored commits produced nothing.

// File: rtl/rhb_pkg.sv
package rhb_pkg;

    localparam int SEQ_W  = 16;
    localparam int AREG_W = 5;
    localparam int PREG_W = 7;

    // Payload of one rename record; the sequence number is stored apart
    typedef struct packed {
        logic [AREG_W-1:0] areg;
        logic [PREG_W-1:0] new_preg;
        logic [PREG_W-1:0] prev_preg;
    } rhb_body_t;

    typedef enum logic [1:0] {
        WALK_IDLE   = 2'd0,
        WALK_UNDO   = 2'd1,
        WALK_RETIRE = 2'd2
    } walk_e;

endpackage

// File: rtl/rhb_store.sv
module rhb_store
    import rhb_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int NSEQ  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                        clk,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [SEQ_W-1:0]            wr_seq,
    input  rhb_body_t                   wr_body,
    input  logic [NSEQ-1:0][IDX_W-1:0]  seq_idx,
    output logic [NSEQ-1:0][SEQ_W-1:0]  seq_out,
    input  logic [IDX_W-1:0]            body_idx,
    output rhb_body_t                   body_out
);

    logic [SEQ_W-1:0] seq_mem  [DEPTH];
    rhb_body_t        body_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            seq_mem[wr_idx]  <= wr_seq;
            body_mem[wr_idx] <= wr_body;
        end
    end

    // Sequence numbers get several read ports for the walk decisions
    for (genvar g = 0; g < NSEQ; g++) begin : g_seq_rd
        assign seq_out[g] = seq_mem[seq_idx[g]];
    end

    assign body_out = body_mem[body_idx];

endmodule

// File: rtl/rhb_age_cmp.sv
module rhb_age_cmp #(
    parameter int W = 16
) (
    input  logic [W-1:0] rec_seq,
    input  logic [W-1:0] bound,
    output logic         younger
);

    assign younger = rec_seq > bound;

endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf
    import rhb_pkg::*;
#(
    parameter int DEPTH    = 8,
    parameter int NUM_PHYS = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_new_preg,
    input  logic [PREG_W-1:0] push_prev_preg,
    output logic              push_ready,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              flush,
    input  logic [SEQ_W-1:0]  commit_seq,
    output logic              busy,
    output logic              map_wr_valid,
    output logic [AREG_W-1:0] map_wr_areg,
    output logic [PREG_W-1:0] map_wr_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg,
    output logic              sb_set_valid,
    output logic [PREG_W-1:0] sb_set_preg,
    output logic              sb_clr_valid,
    output logic [PREG_W-1:0] sb_clr_preg
);

    localparam int IDX_W = $clog2(DEPTH);
    localparam int CNT_W = IDX_W + 1;
    localparam int NSEQ  = 4;
    localparam logic [PREG_W:0]  SPECIAL_BASE = (PREG_W+1)'(NUM_PHYS);
    localparam logic [CNT_W-1:0] FULL_COUNT   = CNT_W'(DEPTH);

    // Sequence read ports: newest, second newest, oldest, second oldest
    localparam int P_NEW  = 0;
    localparam int P_NEW2 = 1;
    localparam int P_OLD  = 2;
    localparam int P_OLD2 = 3;

    typedef struct packed {
        walk_e             mode;
        logic [SEQ_W-1:0]  bound;
        logic              all;
        logic [IDX_W-1:0]  head;
        logic [CNT_W-1:0]  count;
        logic              map_v;
        logic [AREG_W-1:0] map_a;
        logic [PREG_W-1:0] map_p;
        logic              free_v;
        logic [PREG_W-1:0] free_p;
        logic              sbs_v;
        logic [PREG_W-1:0] sbs_p;
        logic              sbc_v;
        logic [PREG_W-1:0] sbc_p;
    } state_t;

    state_t d, q;

    logic [IDX_W-1:0]            tail_idx;
    logic [NSEQ-1:0][IDX_W-1:0]  seq_idx;
    logic [NSEQ-1:0][SEQ_W-1:0]  seq_rd;
    logic [NSEQ-1:0]             younger;
    logic [IDX_W-1:0]            body_idx;
    rhb_body_t                   body_rd;
    rhb_body_t                   push_body;
    walk_e                       eff_mode;
    logic [SEQ_W-1:0]            eff_bound;
    logic                        eff_all;
    logic                        push_ok;

    assign tail_idx         = q.head + q.count[IDX_W-1:0];
    assign seq_idx[P_NEW]   = tail_idx - IDX_W'(1);
    assign seq_idx[P_NEW2]  = tail_idx - IDX_W'(2);
    assign seq_idx[P_OLD]   = q.head;
    assign seq_idx[P_OLD2]  = q.head + IDX_W'(1);

    // Request arbitration: flush, then squash, then an ongoing undo,
    // then a fresh commit, then an ongoing commit
    always_comb begin
        eff_mode  = WALK_IDLE;
        eff_bound = q.bound;
        eff_all   = q.all;
        if (flush) begin
            eff_mode = WALK_UNDO;
            eff_all  = 1'b1;
        end else if (squash_valid) begin
            eff_mode  = WALK_UNDO;
            eff_bound = squash_seq;
            eff_all   = 1'b0;
        end else if (q.mode == WALK_UNDO) begin
            eff_mode = WALK_UNDO;
        end else if (commit_seq != '0) begin
            eff_mode  = WALK_RETIRE;
            eff_bound = commit_seq;
            eff_all   = 1'b0;
        end else if (q.mode == WALK_RETIRE) begin
            eff_mode = WALK_RETIRE;
        end
    end

    for (genvar g = 0; g < NSEQ; g++) begin : g_cmp
        rhb_age_cmp #(.W(SEQ_W)) u_cmp (
            .rec_seq (seq_rd[g]),
            .bound   (eff_bound),
            .younger (younger[g])
        );
    end

    assign body_idx   = (eff_mode == WALK_RETIRE) ? q.head : seq_idx[P_NEW];
    assign push_ready = (q.mode == WALK_IDLE) && (q.count != FULL_COUNT)
                        && !squash_valid && !flush;
    assign push_ok    = push_valid && push_ready;
    assign push_body  = '{areg: push_areg, new_preg: push_new_preg,
                          prev_preg: push_prev_preg};

    rhb_store #(.DEPTH(DEPTH), .NSEQ(NSEQ)) u_store (
        .clk      (clk),
        .wr_en    (push_ok),
        .wr_idx   (tail_idx),
        .wr_seq   (push_seq),
        .wr_body  (push_body),
        .seq_idx  (seq_idx),
        .seq_out  (seq_rd),
        .body_idx (body_idx),
        .body_out (body_rd)
    );

    always_comb begin
        d        = q;
        d.mode   = WALK_IDLE;
        d.bound  = eff_bound;
        d.all    = eff_all;
        d.map_v  = 1'b0;
        d.free_v = 1'b0;
        d.sbs_v  = 1'b0;
        d.sbc_v  = 1'b0;

        case (eff_mode)
            WALK_UNDO: begin
                if (q.count != '0 && (eff_all || younger[P_NEW])) begin
                    d.map_v  = 1'b1;
                    d.map_a  = body_rd.areg;
                    d.map_p  = body_rd.prev_preg;
                    d.free_v = 1'b1;
                    d.free_p = body_rd.new_preg;
                    if ({1'b0, body_rd.new_preg} >= SPECIAL_BASE) begin
                        d.sbs_v = 1'b1;
                        d.sbs_p = body_rd.new_preg;
                    end
                    d.count = q.count - 1'b1;
                    if (q.count > CNT_W'(1) && (eff_all || younger[P_NEW2]))
                        d.mode = WALK_UNDO;
                end
            end
            WALK_RETIRE: begin
                if (q.count != '0 && !younger[P_OLD]) begin
                    d.free_v = 1'b1;
                    d.free_p = body_rd.prev_preg;
                    d.head   = q.head + 1'b1;
                    d.count  = q.count - 1'b1;
                    if (q.count > CNT_W'(1) && !younger[P_OLD2])
                        d.mode = WALK_RETIRE;
                end
            end
            default: ;
        endcase

        if (push_ok) begin
            d.count = d.count + 1'b1;
            d.sbc_v = 1'b1;
            d.sbc_p = push_new_preg;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy         = q.mode != WALK_IDLE;
    assign map_wr_valid = q.map_v;
    assign map_wr_areg  = q.map_a;
    assign map_wr_preg  = q.map_p;
    assign free_valid   = q.free_v;
    assign free_preg    = q.free_p;
    assign sb_set_valid = q.sbs_v;
    assign sb_set_preg  = q.sbs_p;
    assign sb_clr_valid = q.sbc_v;
    assign sb_clr_preg  = q.sbc_p;

endmodule

// File: rtl/rhb_checker.sv
module rhb_checker
    import rhb_pkg::*;
#(
    parameter int NUM_PHYS = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              squash_valid,
    input logic              flush,
    input logic              push_valid,
    input logic              push_ready,
    input logic              busy,
    input logic              map_wr_valid,
    input logic              free_valid,
    input logic              sb_set_valid,
    input logic [PREG_W-1:0] sb_set_preg,
    input logic              sb_clr_valid
);

    localparam logic [PREG_W:0] SPECIAL_BASE = (PREG_W+1)'(NUM_PHYS);

    p_restore_frees_r3: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> free_valid)
        else $error("undo without free");

    p_undo_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> $past(squash_valid || flush || busy))
        else $error("undo without request");

    p_special_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sb_set_valid |-> (map_wr_valid && ({1'b0, sb_set_preg} >= SPECIAL_BASE)))
        else $error("bad ready write");

    p_alloc_follows_push_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sb_clr_valid |-> $past(push_valid && push_ready))
        else $error("allocation strobe without push");

    p_no_push_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !push_ready)
        else $error("push open during walk");

    p_undo_not_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(map_wr_valid && sb_clr_valid))
        else $error("push overlapped undo");

endmodule

bind rename_hist_buf rhb_checker #(.NUM_PHYS(NUM_PHYS)) u_rhb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .squash_valid (squash_valid),
    .flush        (flush),
    .push_valid   (push_valid),
    .push_ready   (push_ready),
    .busy         (busy),
    .map_wr_valid (map_wr_valid),
    .free_valid   (free_valid),
    .sb_set_valid (sb_set_valid),
    .sb_set_preg  (sb_set_preg),
    .sb_clr_valid (sb_clr_valid)
);

// File: tb/rename_hist_buf_test.sv
`timescale 1ns/1ps
module rename_hist_buf_test;
    import rhb_pkg::*;

    localparam int DEPTH    = 8;
    localparam int NUM_PHYS = 96;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              push_valid = 1'b0;
    logic [SEQ_W-1:0]  push_seq = '0;
    logic [AREG_W-1:0] push_areg = '0;
    logic [PREG_W-1:0] push_new_preg = '0;
    logic [PREG_W-1:0] push_prev_preg = '0;
    logic              push_ready;
    logic              squash_valid = 1'b0;
    logic [SEQ_W-1:0]  squash_seq = '0;
    logic              flush = 1'b0;
    logic [SEQ_W-1:0]  commit_seq = '0;
    logic              busy;
    logic              map_wr_valid;
    logic [AREG_W-1:0] map_wr_areg;
    logic [PREG_W-1:0] map_wr_preg;
    logic              free_valid;
    logic [PREG_W-1:0] free_preg;
    logic              sb_set_valid;
    logic [PREG_W-1:0] sb_set_preg;
    logic              sb_clr_valid;
    logic [PREG_W-1:0] sb_clr_preg;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    rename_hist_buf #(.DEPTH(DEPTH), .NUM_PHYS(NUM_PHYS)) uut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic expect_restore(input string req, input int a, input int p,
                                  input int n, input bit special);
        chk(map_wr_valid == 1'b1, req, "map_wr_valid", int'(map_wr_valid), 1);
        chk(int'(map_wr_areg) == a, req, "map_wr_areg", int'(map_wr_areg), a);
        chk(int'(map_wr_preg) == p, req, "map_wr_preg", int'(map_wr_preg), p);
        chk(free_valid == 1'b1, req, "free_valid", int'(free_valid), 1);
        chk(int'(free_preg) == n, req, "free_preg", int'(free_preg), n);
        chk(sb_set_valid == special, req, "sb_set_valid", int'(sb_set_valid), int'(special));
        if (special)
            chk(int'(sb_set_preg) == n, req, "sb_set_preg", int'(sb_set_preg), n);
    endtask

    task automatic expect_retire(input string req, input int p);
        chk(free_valid == 1'b1, req, "free_valid", int'(free_valid), 1);
        chk(int'(free_preg) == p, req, "free_preg", int'(free_preg), p);
        chk(map_wr_valid == 1'b0, req, "map_wr_valid", int'(map_wr_valid), 0);
    endtask

    task automatic expect_quiet(input string req);
        chk(map_wr_valid == 1'b0, req, "map_wr_valid", int'(map_wr_valid), 0);
        chk(free_valid == 1'b0, req, "free_valid", int'(free_valid), 0);
        chk(sb_set_valid == 1'b0, req, "sb_set_valid", int'(sb_set_valid), 0);
    endtask

    task automatic do_push(input int s, input int a, input int n, input int p);
        chk(push_ready == 1'b1, "R2", "push_ready", int'(push_ready), 1);
        push_valid     = 1'b1;
        push_seq       = SEQ_W'(s);
        push_areg      = AREG_W'(a);
        push_new_preg  = PREG_W'(n);
        push_prev_preg = PREG_W'(p);
        step();
        push_valid = 1'b0;
        chk(sb_clr_valid == 1'b1, "R2", "sb_clr_valid", int'(sb_clr_valid), 1);
        chk(int'(sb_clr_preg) == n, "R2", "sb_clr_preg", int'(sb_clr_preg), n);
    endtask

    task automatic do_squash(input int s);
        squash_valid = 1'b1;
        squash_seq   = SEQ_W'(s);
        step();
        squash_valid = 1'b0;
    endtask

    task automatic do_commit(input int c);
        commit_seq = SEQ_W'(c);
        step();
        commit_seq = '0;
    endtask

    // R1: idle outputs after reset
    task automatic t_reset();
        expect_quiet("R1");
        chk(sb_clr_valid == 1'b0, "R1", "sb_clr_valid", int'(sb_clr_valid), 0);
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(push_ready == 1'b1, "R1", "push_ready", int'(push_ready), 1);
    endtask

    // R3, R9: partial squash, newest first, stops at the bound
    task automatic t_squash();
        for (int i = 0; i < 4; i++) do_push(10 + i, 1 + i, 40 + i, 20 + i);
        do_squash(11);
        expect_restore("R3", 4, 23, 43, 1'b0);
        chk(busy == 1'b1, "R9", "busy", int'(busy), 1);
        chk(push_ready == 1'b0, "R9", "push_ready", int'(push_ready), 0);
        step();
        expect_restore("R3", 3, 22, 42, 1'b0);
        chk(busy == 1'b0, "R9", "busy", int'(busy), 0);
        step();
        expect_quiet("R3");
    endtask

    // R5, R6: retire oldest first; no-op commits
    task automatic t_commit();
        do_commit(10);
        expect_retire("R5", 20);
        chk(busy == 1'b0, "R5", "busy", int'(busy), 0);
        step();
        expect_quiet("R5");
        do_commit(5);
        expect_quiet("R6");
        step();
        expect_quiet("R6");
        do_commit(11);
        expect_retire("R5", 21);
        do_commit(50);
        expect_quiet("R6");
    endtask

    // R4, R7: commit alongside squash is dropped; special register rollback
    task automatic t_special();
        do_push(20, 5, 100, 30);
        do_push(21, 6, 50, 31);
        commit_seq = SEQ_W'(40);
        do_squash(20);
        commit_seq = '0;
        expect_restore("R7", 6, 31, 50, 1'b0);
        chk(busy == 1'b0, "R7", "busy", int'(busy), 0);
        step();
        expect_quiet("R7");
        do_squash(19);
        expect_restore("R4", 5, 30, 100, 1'b1);
        step();
        expect_quiet("R4");
    endtask

    // R7: commit while the undo walk runs is ignored
    task automatic t_commit_in_walk();
        for (int i = 0; i < 3; i++) do_push(60 + i, 7 + i, 70 + i, 40 + i);
        do_squash(0);
        expect_restore("R3", 9, 42, 72, 1'b0);
        do_commit(61);
        expect_restore("R7", 8, 41, 71, 1'b0);
        step();
        expect_restore("R7", 7, 40, 70, 1'b0);
        step();
        expect_quiet("R7");
        do_commit(70);
        expect_quiet("R7");
    endtask

    // R10: squash cuts a commit walk short
    task automatic t_abort();
        for (int i = 0; i < 4; i++) do_push(30 + i, 1 + i, 80 + i, 50 + i);
        do_commit(33);
        expect_retire("R10", 50);
        chk(busy == 1'b1, "R10", "busy", int'(busy), 1);
        do_squash(31);
        expect_restore("R10", 4, 53, 83, 1'b0);
        chk(busy == 1'b1, "R10", "busy", int'(busy), 1);
        step();
        expect_restore("R10", 3, 52, 82, 1'b0);
        chk(busy == 1'b0, "R10", "busy", int'(busy), 0);
        step();
        expect_quiet("R10");
        do_commit(40);
        expect_retire("R10", 51);
        step();
        expect_quiet("R10");
    endtask

    // R2, R8: fill the buffer, refuse a push, flush everything
    task automatic t_full_flush();
        for (int i = 0; i < DEPTH; i++) do_push(100 + i, i, 60 + i, 10 + i);
        chk(push_ready == 1'b0, "R2", "push_ready", int'(push_ready), 0);
        push_valid    = 1'b1;
        push_new_preg = PREG_W'(5);
        step();
        push_valid = 1'b0;
        chk(sb_clr_valid == 1'b0, "R2", "sb_clr_valid", int'(sb_clr_valid), 0);
        flush = 1'b1;
        step();
        flush = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            expect_restore("R8", i, 10 + i, 60 + i, 1'b0);
            chk(busy == (i != 0), "R8", "busy", int'(busy), int'(i != 0));
            step();
        end
        expect_quiet("R8");
        chk(push_ready == 1'b1, "R8", "push_ready", int'(push_ready), 1);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_squash();
        t_commit();
        t_special();
        t_commit_in_walk();
        t_abort();
        t_full_flush();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule